// File: doc/BRIEF.md
# Float/Integer Format Converter

This block changes the representation of a 32-bit value between IEEE-754 single precision and 32-bit integers, in either direction. A float can become a two's-complement or an unsigned integer, and a signed or unsigned integer can become a float. The operand, an operation select, a rounding-enable bit and a 2-bit rounding-mode field arrive together with a valid strobe. One clock later the block presents the result with a matching valid pulse and two status flags: invalid (the value could not be represented) and inexact (some nonzero fraction was discarded).

Each operation picks its own rounding. When the rounding-enable bit is low, the conversion truncates toward zero. When it is high, the 2-bit mode field selects nearest-even, toward plus infinity, toward minus infinity or toward zero. Float inputs that cannot fit the integer target saturate, and a NaN gives zero. Integer inputs with more than 24 significant bits are rounded to the 24-bit float significand. Copying raw bits between register files is not handled here. Only this unit changes a value's format.

Top module: `fp_int_convert`

## Requirements
- R1: `op_sel` encodes 00 = float to signed integer, 01 = float to unsigned integer, 10 = signed integer to float, 11 = unsigned integer to float. A request sampled with `in_valid` high produces `out_valid` high with its result and flags on the next clock.
- R2: In a cycle after one where `in_valid` was low, `out_valid` is low and `result`, `flag_invalid` and `flag_inexact` keep their previous values.
- R3: A float operand has its sign at bit 31, an exponent biased by 127 at bits 30..23 and a 23-bit fraction at bits 22..0 with a hidden leading 1. An integral float within the target's range converts exactly and raises no flag.
- R4: With `use_mode` = 0, both directions round toward zero, whatever `rmode` holds.
- R5: With `use_mode` = 1, `rmode` 00 rounds to nearest with ties to even, 01 rounds toward +infinity, 10 rounds toward -infinity and 11 rounds toward zero. For -1.5, -2.5, +1.5 and +2.5 this gives -2,-2,+2,+2 / -1,-2,+2,+3 / -2,-3,+1,+2 / -1,-2,+1,+2 respectively.
- R6: For a signed target, a rounded value above 2^31-1 (or +infinity) gives 0x7FFFFFFF, and one below -2^31 (or -infinity) gives 0x80000000. In both cases invalid is raised.
- R7: For an unsigned target, a negative value that does not round to zero gives 0. A value above 2^32-1 (or +infinity) gives 0xFFFFFFFF. In both cases invalid is raised.
- R8: A NaN operand (exponent all ones, nonzero fraction) converts to 0 with invalid set and inexact clear.
- R9: Inexact is set exactly when a nonzero fraction is discarded and the result is not invalid. Invalid and inexact are never both set.
- R10: Integer-to-float conversions that need 24 significant bits or fewer are exact. Integer 1000 gives 0x447A0000, signed 0x80000000 gives 0xCF000000, and integer-to-float never raises invalid.
- R11: Integer-to-float values with more than 24 significant bits are rounded with the effective mode and raise inexact. A round-up that carries out of the significand increments the exponent. An unsigned source never gives a negative float.
- R12: An integer 0 gives +0.0. Float +0.0 and -0.0 give integer 0 with no flag. After reset, `out_valid`, `result` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation select (see R1) |
| use_mode | input | 1 | 1: apply `rmode`; 0: round toward zero |
| rmode | input | 2 | Rounding mode field (see R5) |
| operand | input | 32 | Float or integer operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Converted value |
| flag_invalid | output | 1 | Result could not be represented |
| flag_inexact | output | 1 | Nonzero fraction discarded |

## Verification
The float-to-integer path is swept over every combination of a band of exponents around the integer range, a set of fraction patterns (zero, half, all ones, near-half), both signs, both targets and all six mode settings. This separates the exact, guard-only, sticky-only and tie cases and the overflow boundaries at 2^31 and 2^32. The integer-to-float path is driven with walking powers of two, powers plus one, all-ones tails and pseudo-random words. These tell the exact short values apart from values that need rounding, including the carry into the next exponent. Directed cases pin the ±1.5/±2.5 table, NaN, both infinities, negative inputs to the unsigned target, and the hold behaviour while idle.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

  typedef enum logic [1:0] {
    OP_F2S = 2'b00,
    OP_F2U = 2'b01,
    OP_S2F = 2'b10,
    OP_U2F = 2'b11
  } cvt_op_e;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_UP      = 2'b01,
    RM_DOWN    = 2'b10,
    RM_ZERO    = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic invalid;
    logic inexact;
  } cvt_flags_t;

endpackage

// File: rtl/fpcvt_round_decide.sv
// Decides whether a truncated magnitude must be incremented by one unit.
module fpcvt_round_decide
  import fpcvt_pkg::*;
(
  input  logic      sign,
  input  logic      lsb,
  input  logic      guard,
  input  logic      sticky,
  input  rnd_mode_e mode,
  output logic      bump
);

  always_comb begin
    unique case (mode)
      RM_NEAREST: bump = guard & (sticky | lsb);
      RM_UP:      bump = ~sign & (guard | sticky);
      RM_DOWN:    bump = sign & (guard | sticky);
      default:    bump = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpcvt_f2i.sv
// Float to 32-bit integer, combinational.
module fpcvt_f2i
  import fpcvt_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [INT_W-1:0] operand,
  input  logic             to_unsigned,
  input  rnd_mode_e        mode,
  output logic [INT_W-1:0] value,
  output cvt_flags_t       flags
);

  localparam int FP_W   = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int E_UNIT = BIAS + FRAC_W;  // exponent at which the lsb weighs 1
  localparam int E_TOP  = BIAS + INT_W;   // largest exponent handled without saturating up front
  localparam int MAG_W  = INT_W + 2;
  localparam logic [MAG_W-1:0] U_MAX   = {2'b00, {INT_W{1'b1}}};
  localparam logic [MAG_W-1:0] S_MAX   = {3'b000, {(INT_W-1){1'b1}}};
  localparam logic [MAG_W-1:0] S_NEGMG = {2'b00, 1'b1, {(INT_W-1){1'b0}}};

  logic                sgn;
  logic [EXP_W-1:0]    ex;
  logic [FRAC_W-1:0]   fr;
  logic [MANT_W-1:0]   mant;
  logic                is_nan;
  logic                huge;
  logic [MAG_W-1:0]    int_part;
  logic                guard;
  logic                sticky;
  logic [2*MANT_W-1:0] wide;
  logic                bump;
  logic [MAG_W-1:0]    mag_r;
  int                  e_i;

  assign sgn    = operand[FP_W-1];
  assign ex     = operand[FP_W-2:FRAC_W];
  assign fr     = operand[FRAC_W-1:0];
  assign mant   = {(ex != '0), fr};
  assign is_nan = (&ex) & (|fr);

  // Alignment: split the magnitude into integer part, guard and sticky.
  always_comb begin
    e_i      = int'(ex);
    int_part = '0;
    guard    = 1'b0;
    sticky   = 1'b0;
    huge     = 1'b0;
    wide     = '0;
    if (e_i > E_TOP) begin
      huge = 1'b1;
    end else if (e_i >= E_UNIT) begin
      int_part = MAG_W'(mant) << (e_i - E_UNIT);
    end else if ((E_UNIT - e_i) <= MANT_W) begin
      wide     = {mant, {MANT_W{1'b0}}} >> (E_UNIT - e_i);
      int_part = MAG_W'(wide[2*MANT_W-1:MANT_W]);
      guard    = wide[MANT_W-1];
      sticky   = |wide[MANT_W-2:0];
    end else begin
      sticky = |mant;
    end
  end

  fpcvt_round_decide u_round (
    .sign   (sgn),
    .lsb    (int_part[0]),
    .guard  (guard),
    .sticky (sticky),
    .mode   (mode),
    .bump   (bump)
  );

  assign mag_r = int_part + MAG_W'(bump);

  // Range check and saturation.
  always_comb begin
    value         = '0;
    flags.invalid = 1'b0;
    flags.inexact = 1'b0;
    if (is_nan) begin
      flags.invalid = 1'b1;
    end else if (to_unsigned) begin
      if (sgn && (huge || (mag_r != '0))) begin
        flags.invalid = 1'b1;
      end else if (huge || (mag_r > U_MAX)) begin
        value         = '1;
        flags.invalid = 1'b1;
      end else begin
        value         = mag_r[INT_W-1:0];
        flags.inexact = guard | sticky;
      end
    end else begin
      if (huge || (!sgn && (mag_r > S_MAX)) || (sgn && (mag_r > S_NEGMG))) begin
        value         = sgn ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
        flags.invalid = 1'b1;
      end else begin
        value         = sgn ? INT_W'(-mag_r) : mag_r[INT_W-1:0];
        flags.inexact = guard | sticky;
      end
    end
  end

endmodule

// File: rtl/fpcvt_i2f.sv
// 32-bit integer to float, combinational. Needs INT_W >= FRAC_W + 3.
module fpcvt_i2f
  import fpcvt_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [INT_W-1:0] operand,
  input  logic             from_signed,
  input  rnd_mode_e        mode,
  output logic [INT_W-1:0] value,
  output logic             inexact
);

  localparam int MANT_W = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int IDX_W  = $clog2(INT_W);
  localparam int DROP_W = INT_W - MANT_W;  // bits below the kept significand

  logic              neg;
  logic [INT_W-1:0]  mag;
  logic [IDX_W-1:0]  msb;
  logic [IDX_W-1:0]  shamt;
  logic [INT_W-1:0]  norm;
  logic [MANT_W-1:0] kept;
  logic              guard;
  logic              sticky;
  logic              bump;
  logic [MANT_W:0]   kept_r;
  logic [EXP_W-1:0]  biased;
  logic [FRAC_W-1:0] frac;

  assign neg = from_signed & operand[INT_W-1];
  assign mag = neg ? (~operand + INT_W'(1)) : operand;

  // Leading-one position.
  always_comb begin
    msb = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) msb = IDX_W'(i);
    end
  end

  assign shamt  = IDX_W'(INT_W - 1) - msb;
  assign norm   = mag << shamt;
  assign kept   = norm[INT_W-1 -: MANT_W];
  assign guard  = norm[DROP_W-1];
  assign sticky = |norm[DROP_W-2:0];

  fpcvt_round_decide u_round (
    .sign   (neg),
    .lsb    (kept[0]),
    .guard  (guard),
    .sticky (sticky),
    .mode   (mode),
    .bump   (bump)
  );

  assign kept_r = {1'b0, kept} + (MANT_W+1)'(bump);
  assign frac   = kept_r[MANT_W] ? kept_r[MANT_W:1+1-1] [FRAC_W-1:0] : kept_r[FRAC_W-1:0];
  assign biased = EXP_W'(BIAS) + EXP_W'(msb) + EXP_W'(kept_r[MANT_W]);

  always_comb begin
    if (mag == '0) begin
      value   = '0;
      inexact = 1'b0;
    end else begin
      value   = {neg, biased, frac};
      inexact = guard | sticky;
    end
  end

endmodule

// File: rtl/fp_int_convert.sv
// Float/integer converter: one registered stage after combinational datapaths.
module fp_int_convert
  import fpcvt_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op_sel,
  input  logic             use_mode,
  input  logic [1:0]       rmode,
  input  logic [INT_W-1:0] operand,
  output logic             out_valid,
  output logic [INT_W-1:0] result,
  output logic             flag_invalid,
  output logic             flag_inexact
);

  logic             rst_meta;
  logic             rst_sync_n;
  cvt_op_e          op;
  rnd_mode_e        eff_mode;
  logic [INT_W-1:0] f2i_val;
  cvt_flags_t       f2i_flags;
  logic [INT_W-1:0] i2f_val;
  logic             i2f_inexact;
  logic [INT_W-1:0] res_d;
  cvt_flags_t       flags_d;
  logic             valid_q;
  logic [INT_W-1:0] res_q;
  cvt_flags_t       flags_q;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign op       = cvt_op_e'(op_sel);
  assign eff_mode = use_mode ? rnd_mode_e'(rmode) : RM_ZERO;

  fpcvt_f2i #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_f2i (
    .operand     (operand),
    .to_unsigned (op == OP_F2U),
    .mode        (eff_mode),
    .value       (f2i_val),
    .flags       (f2i_flags)
  );

  fpcvt_i2f #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_i2f (
    .operand     (operand),
    .from_signed (op == OP_S2F),
    .mode        (eff_mode),
    .value       (i2f_val),
    .inexact     (i2f_inexact)
  );

  // Next state.
  always_comb begin
    if (op == OP_S2F || op == OP_U2F) begin
      res_d           = i2f_val;
      flags_d.invalid = 1'b0;
      flags_d.inexact = i2f_inexact;
    end else begin
      res_d   = f2i_val;
      flags_d = f2i_flags;
    end
  end

  // Registers, loaded only on a request.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign out_valid    = valid_q;
  assign result       = res_q;
  assign flag_invalid = flags_q.invalid;
  assign flag_inexact = flags_q.inexact;

endmodule

// File: rtl/fp_int_convert_chk.sv
module fp_int_convert_chk #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       op_sel,
  input logic [INT_W-1:0] operand,
  input logic             out_valid,
  input logic [INT_W-1:0] result,
  input logic             flag_invalid,
  input logic             flag_inexact
);

  localparam int FP_W = 1 + EXP_W + FRAC_W;

  logic op_is_nan;
  assign op_is_nan = (&operand[FP_W-2:FRAC_W]) & (|operand[FRAC_W-1:0]);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_invalid) && $stable(flag_inexact)));

  assert_signed_positive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b00 && !operand[INT_W-1]) |=> !result[INT_W-1]);

  assert_nan_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sel[1] && op_is_nan) |=> (result == '0 && flag_invalid && !flag_inexact));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_invalid && flag_inexact));

  assert_int_source_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[1]) |=> !flag_invalid);

  assert_unsigned_source_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b11) |=> !result[INT_W-1]);

  assert_zero_int_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[1] && operand == '0) |=> (result == '0 && !flag_inexact));

endmodule

bind fp_int_convert fp_int_convert_chk #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .op_sel       (op_sel),
  .operand      (operand),
  .out_valid    (out_valid),
  .result       (result),
  .flag_invalid (flag_invalid),
  .flag_inexact (flag_inexact)
);

// File: tb/fp_int_convert_bench.sv
module fp_int_convert_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic        use_mode;
  logic [1:0]  rmode;
  logic [31:0] operand;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_invalid;
  logic        flag_inexact;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  fp_int_convert u_fp_int_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .use_mode(use_mode), .rmode(rmode), .operand(operand),
    .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Mode index: 0..3 = rounding field with use_mode=1, 4/5 = plain with field 00/01.
  function automatic int eff_of(input int m);
    return (m >= 4) ? 3 : m;
  endfunction

  function automatic real rnd(input real v, input int mode);
    real f;
    case (mode)
      0: begin
        f = $floor(v);
        if (v - f > 0.5) f = f + 1.0;
        else if (v - f == 0.5 && $floor(f / 2.0) * 2.0 != f) f = f + 1.0;
        return f;
      end
      1: return $ceil(v);
      2: return $floor(v);
      default: return (v < 0.0) ? -$floor(-v) : $floor(v);
    endcase
  endfunction

  task automatic exp_f2i(input logic [31:0] b, input bit uns, input int mode,
                         output logic [31:0] r, output bit inv, output bit inx);
    int  e;
    real v;
    real q;
    e = int'(b[30:23]);
    inv = 0; inx = 0; r = 0;
    if (e == 255 && b[22:0] != 0) begin
      inv = 1;
      return;
    end
    if (e == 255) v = 1.0e300;
    else if (e == 0) v = real'(b[22:0]) * (2.0 ** (-149));
    else v = (real'(b[22:0]) + 8388608.0) * (2.0 ** (e - 150));
    if (b[31]) v = -v;
    q = rnd(v, mode);
    if (uns) begin
      if (q < 0.0) inv = 1;
      else if (q > 4294967295.0) begin inv = 1; r = 32'hFFFF_FFFF; end
    end else begin
      if (q > 2147483647.0) begin inv = 1; r = 32'h7FFF_FFFF; end
      else if (q < -2147483648.0) begin inv = 1; r = 32'h8000_0000; end
    end
    if (!inv) begin
      r   = 32'(longint'(q));
      inx = (q != v);
    end
  endtask

  task automatic exp_i2f(input logic [31:0] a, input bit uns, input int mode,
                         output logic [31:0] r, output bit inx);
    real v;
    real av;
    real sc;
    real q;
    real aq;
    int  k;
    bit  s;
    v = uns ? real'(longint'({32'b0, a})) : real'(longint'(signed'(a)));
    r = 0; inx = 0;
    if (v == 0.0) return;
    s  = (v < 0.0);
    av = s ? -v : v;
    k  = 0;
    while (2.0 ** (k + 1) <= av) k++;
    sc  = 2.0 ** (k - 23);
    q   = rnd(v / sc, mode);
    inx = (q * sc != v);
    aq  = (q < 0.0) ? -q : q;
    if (aq == 16777216.0) begin aq = aq / 2.0; k++; end
    r = {s, 8'(k + 127), 23'(longint'(aq) - 64'sd8388608)};
  endtask

  task automatic run_op(input logic [1:0] op, input int m, input logic [31:0] a);
    @(negedge clk);
    op_sel   = op;
    use_mode = (m < 4);
    rmode    = (m < 4) ? 2'(m) : 2'(m - 4);
    operand  = a;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input bit ei, input bit ex);
    tests++;
    if (out_valid !== 1'b1 || result !== er || flag_invalid !== ei || flag_inexact !== ex) begin
      fails++;
      $display("FAIL %s op=%b mode=%0d/%b in=%h: got valid=%b res=%h inv=%b inx=%b, expected valid=1 res=%h inv=%b inx=%b",
               tag, op_sel, use_mode, rmode, operand, out_valid, result, flag_invalid, flag_inexact, er, ei, ex);
    end
  endtask

  task automatic f2i_case(input string tag, input bit uns, input int m, input logic [31:0] a);
    logic [31:0] er;
    bit ei;
    bit ex;
    exp_f2i(a, uns, eff_of(m), er, ei, ex);
    run_op(uns ? 2'b01 : 2'b00, m, a);
    check(tag, er, ei, ex);
  endtask

  task automatic i2f_case(input string tag, input bit uns, input int m, input logic [31:0] a);
    logic [31:0] er;
    bit ex;
    exp_i2f(a, uns, eff_of(m), er, ex);
    run_op(uns ? 2'b11 : 2'b10, m, a);
    check(tag, er, 1'b0, ex);
  endtask

  task automatic direct(input string tag, input logic [1:0] op, input int m, input logic [31:0] a,
                        input logic [31:0] er, input bit ei, input bit ex);
    run_op(op, m, a);
    check(tag, er, ei, ex);
  endtask

  initial begin
    logic [31:0] fracs [8];
    logic [31:0] lf;
    logic [31:0] tv [4];
    int          tab [4][4];
    logic [31:0] held;

    fracs = '{32'h0, 32'h1, 32'h400000, 32'h7FFFFF, 32'h200000, 32'h600001, 32'h3FFFFF, 32'h155555};
    tv    = '{32'hBFC0_0000, 32'hC020_0000, 32'h3FC0_0000, 32'h4020_0000};
    tab   = '{'{-2, -2, 2, 2}, '{-1, -2, 2, 3}, '{-2, -3, 1, 2}, '{-1, -2, 1, 2}};

    rst_n = 1'b0; in_valid = 1'b0; op_sel = 2'b00; use_mode = 1'b0; rmode = 2'b00; operand = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    tests++;
    if (out_valid !== 1'b0 || result !== 32'h0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
      fails++;
      $display("FAIL R12 reset: got valid=%b res=%h inv=%b inx=%b, expected all 0",
               out_valid, result, flag_invalid, flag_inexact);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5: tie table in every enabled mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 4; i++)
        direct("R5 tie table", 2'b00, m, tv[i], 32'(tab[m][i]), 1'b0, 1'b1);
    // R4: plain conversion truncates even with field set to nearest or up
    direct("R4 plain trunc", 2'b00, 4, 32'h4020_0000, 32'd2, 1'b0, 1'b1);
    direct("R4 plain trunc", 2'b00, 5, 32'hC020_0000, -32'sd2, 1'b0, 1'b1);
    direct("R4 plain i2f",   2'b10, 5, 32'h0100_0001, 32'h4B80_0000, 1'b0, 1'b1);
    // R3: exact integral values
    direct("R3 exact", 2'b00, 0, 32'h447A_0000, 32'd1000, 1'b0, 1'b0);
    direct("R3 exact", 2'b00, 0, 32'hCF00_0000, 32'h8000_0000, 1'b0, 1'b0);
    direct("R3 exact", 2'b01, 0, 32'h4F7F_FFFF, 32'hFFFF_FF00, 1'b0, 1'b0);
    // R6: signed saturation
    direct("R6 sat pos", 2'b00, 0, 32'h4F00_0000, 32'h7FFF_FFFF, 1'b1, 1'b0);
    direct("R6 +inf",    2'b00, 3, 32'h7F80_0000, 32'h7FFF_FFFF, 1'b1, 1'b0);
    direct("R6 -inf",    2'b00, 3, 32'hFF80_0000, 32'h8000_0000, 1'b1, 1'b0);
    // R7: unsigned target
    direct("R7 negative", 2'b01, 0, 32'hBF80_0000, 32'h0, 1'b1, 1'b0);
    direct("R7 -0.5 rz",  2'b01, 3, 32'hBF00_0000, 32'h0, 1'b0, 1'b1);
    direct("R7 -0.5 dn",  2'b01, 2, 32'hBF00_0000, 32'h0, 1'b1, 1'b0);
    direct("R7 2^31",     2'b01, 0, 32'h4F00_0000, 32'h8000_0000, 1'b0, 1'b0);
    direct("R7 +inf",     2'b01, 0, 32'h7F80_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
    // R8: NaN
    direct("R8 nan", 2'b00, 1, 32'h7FC0_0000, 32'h0, 1'b1, 1'b0);
    direct("R8 nan", 2'b01, 0, 32'hFF80_0001, 32'h0, 1'b1, 1'b0);
    // R10, R11, R12: integer sources
    direct("R10 int 1000",   2'b10, 0, 32'd1000, 32'h447A_0000, 1'b0, 1'b0);
    direct("R10 int min",    2'b10, 0, 32'h8000_0000, 32'hCF00_0000, 1'b0, 1'b0);
    direct("R11 round rne",  2'b11, 0, 32'h0100_0001, 32'h4B80_0000, 1'b0, 1'b1);
    direct("R11 round up",   2'b11, 1, 32'h0100_0001, 32'h4B80_0001, 1'b0, 1'b1);
    direct("R11 carry",      2'b11, 0, 32'h01FF_FFFF, 32'h4C00_0000, 1'b0, 1'b1);
    direct("R11 uns max",    2'b11, 3, 32'hFFFF_FFFF, 32'h4F7F_FFFF, 1'b0, 1'b1);
    direct("R12 int zero",   2'b10, 0, 32'h0, 32'h0, 1'b0, 1'b0);
    direct("R12 neg zero",   2'b00, 0, 32'h8000_0000, 32'h0, 1'b0, 1'b0);
    // R2: idle hold and R1 valid pulse
    held = result;
    @(negedge clk);
    op_sel = 2'b00; operand = 32'h4120_0000; in_valid = 1'b0;
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || result !== held) begin
      fails++;
      $display("FAIL R2 hold: got valid=%b res=%h, expected valid=0 res=%h", out_valid, result, held);
    end

    // R3/R5/R6/R7/R9 sweep, float source
    for (int s = 0; s < 2; s++)
      for (int u = 0; u < 2; u++)
        for (int m = 0; m < 6; m++) begin
          for (int e = 118; e < 165; e++)
            for (int f = 0; f < 8; f++) begin
              int ee;
              ee = (e <= 160) ? e : ((e == 161) ? 0 : ((e == 162) ? 1 : ((e == 163) ? 254 : 255)));
              f2i_case("R9 f2i sweep", u[0], m, {s[0], 8'(ee), fracs[f][22:0]});
            end
        end

    // R1/R10/R11 sweep, integer source
    lf = 32'h1234_5679;
    for (int u = 0; u < 2; u++)
      for (int m = 0; m < 6; m++) begin
        for (int k = 0; k < 32; k++) begin
          i2f_case("R10 i2f walk", u[0], m, 32'h1 << k);
          i2f_case("R11 i2f plus1", u[0], m, (32'h1 << k) + 32'h1);
          i2f_case("R11 i2f tail", u[0], m, 32'hFFFF_FFFF >> k);
          i2f_case("R11 i2f neg", u[0], m, ~(32'h1 << k));
        end
        for (int n = 0; n < 120; n++) begin
          lf = lf ^ (lf << 13);
          lf = lf ^ (lf >> 17);
          lf = lf ^ (lf << 5);
          i2f_case("R1 i2f random", u[0], m, lf);
        end
      end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule